// File: doc/BRIEF.md
# Load-Linked / Store-Conditional Reservation Monitor

This block keeps a small table of line reservations, each owned by a requester identifier, and resolves atomic and write-class operations at the moment they complete. A completing load-linked places or refreshes a reservation on its line. A completing store-conditional reports success only when the same requester still holds that line. Every store-conditional clears the line. An ordinary write from the owner also clears the reservation.

The block also tracks locked read-modify-write pairs. The read half blocks the request queue for its line, and the write half releases the block. While the block is in place, a request that targets the blocked line is stalled, and requests to any other line pass. A combinational classifier gives the request class that the request path sends downstream. Load-linked and store-conditional go out as atomics. Locked read-modify-writes go out as stores, so that they obtain exclusive permission.

Top module: `llsc_monitor`

## Requirements
- R1: A completing load-linked (op 2) records its line as reserved by its requester. `lock_held_o` then reads 1 for that line/ID pair, and the response reports success.
- R2: A completing store-conditional (op 3) responds with `rsp_ok_o`=1 only if its line is reserved by the same requester ID; otherwise `rsp_ok_o`=0.
- R3: Every completing store-conditional removes the reservation on its line, whatever the owner and whatever the outcome.
- R4: Completing plain writes (store op 1, read-modify-write op 7, locked RMW read op 4, locked RMW write op 5) clear a reservation only when the requester is the owner. Loads (op 0) and instruction fetches (op 6) leave reservations unchanged.
- R5: A completing locked RMW read (op 4) raises `queue_block_o`, with `block_line_o` set to its line. A completing locked RMW write (op 5) to the same line drops the block. A locked RMW write to another line has no effect on the block.
- R6: `req_stall_o` is 1 exactly when `req_valid_i` is 1, a block is active, and `req_line_i` equals the blocked line.
- R7: `req_class_o` encodes ifetch=0, load=1, store=2, atomic=3. Op 6 maps to 0 and op 0 to 1. Ops 1, 4, 5 and 7 map to 2. Ops 2 and 3 map to 3.
- R8: A load-linked to a line that is already reserved replaces the owner in place. A load-linked to a new line fills the lowest free entry. When no entry is free, it evicts entries in round-robin order, starting at entry 0, and the pointer advances only on an eviction.
- R9: `rsp_valid_o` and `rsp_ok_o` appear on the cycle after the completion strobe. After reset there are no reservations, no block and no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cmp_valid_i | input | 1 | Completion strobe |
| cmp_op_i | input | 3 | Completing operation type |
| cmp_line_i | input | LINE_W | Line address of the completion |
| cmp_id_i | input | ID_W | Requester ID of the completion |
| req_valid_i | input | 1 | New request present |
| req_op_i | input | 3 | New request operation type |
| req_line_i | input | LINE_W | New request line address, also the reservation probe line |
| req_id_i | input | ID_W | New request requester ID, also the reservation probe ID |
| rsp_valid_o | output | 1 | Completion result valid |
| rsp_ok_o | output | 1 | Completion result success bit |
| lock_held_o | output | 1 | Probe line is reserved by probe ID |
| queue_block_o | output | 1 | Request queue blocked for a line |
| block_line_o | output | LINE_W | Currently blocked line |
| req_stall_o | output | 1 | New request must be held off |
| req_class_o | output | 2 | Downstream request class |

## Verification
The assertions check several properties on every cycle:
- the store-conditional result agrees with the reservation seen on the probe just before completion;
- a store-conditional or a load-linked leaves the probe showing the expected state;
- a stall never occurs without a block;
- the block line follows the locked read;
- atomics are classified as such.

Only the bench scenarios can show other behaviour:
- round-robin eviction order and reuse of freed entries;
- owner-only clearing for each write-class op across all ID pairs;
- the line selectivity of the stall.

// File: rtl/llsc_pkg.sv
package llsc_pkg;
  typedef enum logic [2:0] {
    OP_LOAD   = 3'd0,
    OP_STORE  = 3'd1,
    OP_LL     = 3'd2,
    OP_SC     = 3'd3,
    OP_LRMW_R = 3'd4,
    OP_LRMW_W = 3'd5,
    OP_IFETCH = 3'd6,
    OP_RMW    = 3'd7
  } op_e;

  typedef enum logic [1:0] {
    CLS_IFETCH = 2'd0,
    CLS_LOAD   = 2'd1,
    CLS_STORE  = 2'd2,
    CLS_ATOMIC = 2'd3
  } cls_e;

  function automatic logic is_plain_write(op_e op);
    return (op == OP_STORE) || (op == OP_RMW) ||
           (op == OP_LRMW_R) || (op == OP_LRMW_W);
  endfunction
endpackage

// File: rtl/llsc_req_class.sv
module llsc_req_class
  import llsc_pkg::*;
(
  input  logic [2:0] op_i,
  output logic [1:0] cls_o
);
  cls_e cls;
  always_comb begin
    unique case (op_e'(op_i))
      OP_IFETCH:           cls = CLS_IFETCH;
      OP_LOAD:             cls = CLS_LOAD;
      OP_LL, OP_SC:        cls = CLS_ATOMIC;
      default:             cls = CLS_STORE;
    endcase
  end
  assign cls_o = cls;
endmodule

// File: rtl/llsc_block_ctl.sv
module llsc_block_ctl
  import llsc_pkg::*;
#(
  parameter int LINE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              upd_i,
  input  logic [2:0]        op_i,
  input  logic [LINE_W-1:0] line_i,
  input  logic              req_valid_i,
  input  logic [LINE_W-1:0] req_line_i,
  output logic              block_o,
  output logic [LINE_W-1:0] block_line_o,
  output logic              stall_o
);
  logic              blk_q;
  logic [LINE_W-1:0] blk_line_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      blk_q      <= 1'b0;
      blk_line_q <= '0;
    end else if (upd_i) begin
      if (op_e'(op_i) == OP_LRMW_R) begin
        blk_q      <= 1'b1;
        blk_line_q <= line_i;
      end else if (op_e'(op_i) == OP_LRMW_W && blk_q && blk_line_q == line_i) begin
        blk_q <= 1'b0;
      end
    end
  end

  assign block_o      = blk_q;
  assign block_line_o = blk_line_q;
  assign stall_o      = req_valid_i && blk_q && (req_line_i == blk_line_q);
endmodule

// File: rtl/llsc_resv_table.sv
module llsc_resv_table
  import llsc_pkg::*;
#(
  parameter int LINE_W      = 8,
  parameter int ID_W        = 2,
  parameter int NUM_ENTRIES = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              upd_i,
  input  logic [2:0]        op_i,
  input  logic [LINE_W-1:0] line_i,
  input  logic [ID_W-1:0]   id_i,
  output logic              own_hit_o,
  input  logic [LINE_W-1:0] probe_line_i,
  input  logic [ID_W-1:0]   probe_id_i,
  output logic              probe_hit_o
);
  localparam int IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_ENTRIES - 1);

  logic [NUM_ENTRIES-1:0] vld_q;
  logic [LINE_W-1:0]      line_q [NUM_ENTRIES];
  logic [ID_W-1:0]        own_q  [NUM_ENTRIES];
  logic [IDX_W-1:0]       rr_q;

  logic [NUM_ENTRIES-1:0] line_m, own_m, probe_m;

  for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_match
    assign line_m[e]  = vld_q[e] && (line_q[e] == line_i);
    assign own_m[e]   = line_m[e] && (own_q[e] == id_i);
    assign probe_m[e] = vld_q[e] && (line_q[e] == probe_line_i) && (own_q[e] == probe_id_i);
  end

  assign own_hit_o   = |own_m;
  assign probe_hit_o = |probe_m;

  logic             hit_any, free_any;
  logic [IDX_W-1:0] hit_idx, free_idx;

  always_comb begin
    hit_any  = 1'b0;
    free_any = 1'b0;
    hit_idx  = '0;
    free_idx = '0;
    for (int e = 0; e < NUM_ENTRIES; e++) begin
      if (!hit_any && line_m[e]) begin
        hit_any = 1'b1;
        hit_idx = IDX_W'(e);
      end
      if (!free_any && !vld_q[e]) begin
        free_any = 1'b1;
        free_idx = IDX_W'(e);
      end
    end
  end

  op_e op;
  assign op = op_e'(op_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= '0;
      rr_q  <= '0;
      for (int e = 0; e < NUM_ENTRIES; e++) begin
        line_q[e] <= '0;
        own_q[e]  <= '0;
      end
    end else if (upd_i) begin
      if (op == OP_LL) begin
        if (hit_any) begin
          own_q[hit_idx] <= id_i;
        end else if (free_any) begin
          vld_q[free_idx]  <= 1'b1;
          line_q[free_idx] <= line_i;
          own_q[free_idx]  <= id_i;
        end else begin
          line_q[rr_q] <= line_i;
          own_q[rr_q]  <= id_i;
          rr_q         <= (rr_q == LAST_IDX) ? '0 : rr_q + 1'b1;
        end
      end else if (op == OP_SC) begin
        for (int e = 0; e < NUM_ENTRIES; e++)
          if (line_m[e]) vld_q[e] <= 1'b0;
      end else if (is_plain_write(op)) begin
        for (int e = 0; e < NUM_ENTRIES; e++)
          if (own_m[e]) vld_q[e] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/llsc_monitor.sv
module llsc_monitor
  import llsc_pkg::*;
#(
  parameter int LINE_W      = 8,
  parameter int ID_W        = 2,
  parameter int NUM_ENTRIES = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmp_valid_i,
  input  logic [2:0]        cmp_op_i,
  input  logic [LINE_W-1:0] cmp_line_i,
  input  logic [ID_W-1:0]   cmp_id_i,
  input  logic              req_valid_i,
  input  logic [2:0]        req_op_i,
  input  logic [LINE_W-1:0] req_line_i,
  input  logic [ID_W-1:0]   req_id_i,
  output logic              rsp_valid_o,
  output logic              rsp_ok_o,
  output logic              lock_held_o,
  output logic              queue_block_o,
  output logic [LINE_W-1:0] block_line_o,
  output logic              req_stall_o,
  output logic [1:0]        req_class_o
);
  logic own_hit;

  llsc_resv_table #(
    .LINE_W(LINE_W), .ID_W(ID_W), .NUM_ENTRIES(NUM_ENTRIES)
  ) u_table (
    .clk_i, .rst_ni,
    .upd_i       (cmp_valid_i),
    .op_i        (cmp_op_i),
    .line_i      (cmp_line_i),
    .id_i        (cmp_id_i),
    .own_hit_o   (own_hit),
    .probe_line_i(req_line_i),
    .probe_id_i  (req_id_i),
    .probe_hit_o (lock_held_o)
  );

  llsc_block_ctl #(.LINE_W(LINE_W)) u_block (
    .clk_i, .rst_ni,
    .upd_i       (cmp_valid_i),
    .op_i        (cmp_op_i),
    .line_i      (cmp_line_i),
    .req_valid_i (req_valid_i),
    .req_line_i  (req_line_i),
    .block_o     (queue_block_o),
    .block_line_o(block_line_o),
    .stall_o     (req_stall_o)
  );

  llsc_req_class u_class (.op_i(req_op_i), .cls_o(req_class_o));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_ok_o    <= 1'b0;
    end else begin
      rsp_valid_o <= cmp_valid_i;
      rsp_ok_o    <= cmp_valid_i && ((op_e'(cmp_op_i) != OP_SC) || own_hit);
    end
  end
endmodule

// File: rtl/llsc_monitor_chk.sv
module llsc_monitor_chk
  import llsc_pkg::*;
#(
  parameter int LINE_W = 8,
  parameter int ID_W   = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cmp_valid_i,
  input logic [2:0]        cmp_op_i,
  input logic [LINE_W-1:0] cmp_line_i,
  input logic [ID_W-1:0]   cmp_id_i,
  input logic              req_valid_i,
  input logic [2:0]        req_op_i,
  input logic [LINE_W-1:0] req_line_i,
  input logic [ID_W-1:0]   req_id_i,
  input logic              rsp_valid_o,
  input logic              rsp_ok_o,
  input logic              lock_held_o,
  input logic              queue_block_o,
  input logic [LINE_W-1:0] block_line_o,
  input logic              req_stall_o,
  input logic [1:0]        req_class_o
);
  logic probe_same;
  assign probe_same = (req_line_i == cmp_line_i) && (req_id_i == cmp_id_i);

  p_sc_result_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmp_valid_i && cmp_op_i == OP_SC && probe_same |=> rsp_ok_o == $past(lock_held_o));

  p_sc_clear_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmp_valid_i && cmp_op_i == OP_SC && probe_same |=>
      (!($stable(req_line_i) && $stable(req_id_i)) || !lock_held_o));

  p_ll_set_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmp_valid_i && cmp_op_i == OP_LL && probe_same |=>
      rsp_ok_o && (!($stable(req_line_i) && $stable(req_id_i)) || lock_held_o));

  p_block_set_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmp_valid_i && cmp_op_i == OP_LRMW_R |=>
      queue_block_o && block_line_o == $past(cmp_line_i));

  p_stall_needs_block_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_stall_o |-> req_valid_i && queue_block_o && req_line_i == block_line_o);

  p_rsp_timing_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmp_valid_i |=> rsp_valid_o);

  p_atomic_class_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_op_i == OP_LL || req_op_i == OP_SC) |-> req_class_o == CLS_ATOMIC);
endmodule

bind llsc_monitor llsc_monitor_chk #(.LINE_W(LINE_W), .ID_W(ID_W)) u_chk (.*);

// File: tb/sim_llsc_monitor.sv
`timescale 1ns/1ps
module sim_llsc_monitor;
  localparam int LW = 8;
  localparam int IW = 2;

  logic clk = 0, rst_n = 0;
  logic cmp_valid = 0, req_valid = 0;
  logic [2:0] cmp_op = 0, req_op = 0;
  logic [LW-1:0] cmp_line = 0, req_line = 0;
  logic [IW-1:0] cmp_id = 0, req_id = 0;
  logic rsp_valid, rsp_ok, lock_held, queue_block, req_stall;
  logic [LW-1:0] block_line;
  logic [1:0] req_class;

  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  llsc_monitor #(.LINE_W(LW), .ID_W(IW), .NUM_ENTRIES(4)) u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .cmp_valid_i(cmp_valid), .cmp_op_i(cmp_op), .cmp_line_i(cmp_line), .cmp_id_i(cmp_id),
    .req_valid_i(req_valid), .req_op_i(req_op), .req_line_i(req_line), .req_id_i(req_id),
    .rsp_valid_o(rsp_valid), .rsp_ok_o(rsp_ok), .lock_held_o(lock_held),
    .queue_block_o(queue_block), .block_line_o(block_line),
    .req_stall_o(req_stall), .req_class_o(req_class)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0;
    cmp_valid = 0;
    req_valid = 0;
    @(negedge clk);
    rst_n = 1;
  endtask

  task automatic complete(input int op, input int line, input int id, output logic ok);
    @(negedge clk);
    cmp_valid = 1; cmp_op = 3'(op); cmp_line = LW'(line); cmp_id = IW'(id);
    @(negedge clk);
    cmp_valid = 0;
    chk("R9 rsp_valid", int'(rsp_valid), 1);
    ok = rsp_ok;
  endtask

  task automatic probe(input int line, input int id, input int exp, input string req);
    req_line = LW'(line); req_id = IW'(id);
    #0.5;
    chk(req, int'(lock_held), exp);
  endtask

  logic ok;

  initial begin
    #20000;
    errors++;
    $display("FAIL watchdog act=0 exp=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    do_reset();
    // R9 reset state
    chk("R9 rsp_valid reset", int'(rsp_valid), 0);
    chk("R9 block reset", int'(queue_block), 0);
    for (int l = 0; l < 4; l++) probe(l, 0, 0, "R9 no locks");

    // R7 class for every op
    for (int o = 0; o < 8; o++) begin
      int exp;
      req_op = 3'(o);
      #0.5;
      exp = (o == 6) ? 0 : (o == 0) ? 1 : (o == 2 || o == 3) ? 3 : 2;
      chk("R7 class", int'(req_class), exp);
    end

    // R1/R2/R3 all owner/SC-requester pairs
    for (int a = 0; a < 4; a++)
      for (int b = 0; b < 4; b++) begin
        complete(2, 8'h40, a, ok);
        chk("R1 ll ok", int'(ok), 1);
        probe(8'h40, a, 1, "R1 ll held");
        complete(3, 8'h40, b, ok);
        chk("R2 sc result", int'(ok), (a == b) ? 1 : 0);
        probe(8'h40, a, 0, "R3 sc clears");
      end
    // R2 SC with no reservation
    complete(3, 8'h41, 1, ok);
    chk("R2 sc unlocked", int'(ok), 0);

    // R4 write class owner-only clear
    for (int o = 0; o < 8; o++)
      for (int a = 0; a < 4; a++)
        for (int w = 0; w < 4; w++) begin
          if (o == 2 || o == 3) continue;
          complete(2, 8'h20, a, ok);
          complete(o, 8'h20, w, ok);
          probe(8'h20, a,
                ((o == 1 || o == 4 || o == 5 || o == 7) && a == w) ? 0 : 1, "R4 write clear");
          complete(3, 8'h20, 0, ok);
        end
    complete(5, 8'h20, 0, ok);

    // R8 replacement
    do_reset();
    for (int l = 10; l < 16; l++) complete(2, l, 1, ok);
    probe(10, 1, 0, "R8 rr evict 0");
    probe(11, 1, 0, "R8 rr evict 1");
    for (int l = 12; l < 16; l++) probe(l, 1, 1, "R8 kept");
    complete(3, 12, 1, ok);
    complete(2, 16, 2, ok);
    probe(16, 2, 1, "R8 free reuse");
    complete(2, 17, 2, ok);
    probe(16, 2, 0, "R8 rr ptr");
    probe(13, 1, 1, "R8 rr kept");
    probe(17, 2, 1, "R8 new");
    complete(2, 13, 3, ok);
    probe(13, 1, 0, "R8 in-place old owner");
    probe(13, 3, 1, "R8 in-place new owner");

    // R5/R6 blocking
    do_reset();
    complete(4, 5, 0, ok);
    chk("R5 block set", int'(queue_block), 1);
    chk("R5 block line", int'(block_line), 5);
    req_valid = 1;
    for (int l = 0; l < 16; l++) begin
      req_line = LW'(l);
      #0.5;
      chk("R6 stall", int'(req_stall), (l == 5) ? 1 : 0);
    end
    req_valid = 0;
    req_line = 5;
    #0.5;
    chk("R6 no valid", int'(req_stall), 0);
    complete(5, 6, 0, ok);
    chk("R5 other line", int'(queue_block), 1);
    complete(5, 5, 0, ok);
    chk("R5 release", int'(queue_block), 0);
    req_valid = 1;
    #0.5;
    chk("R6 released", int'(req_stall), 0);
    req_valid = 0;

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule